// File: doc/BRIEF.md
# Posted-Write Buffer with Line Eviction Store

This block sits between a data cache and the memory bus so that the core can post its stores and keep running. A main queue takes single-word writes: stores to regions that are uncached but may be buffered, write-through stores, and stores that miss in a write-back region. The queue keeps its address bookkeeping apart from its data storage. It has sixteen word slots and four address entries. A store whose word address directly follows the last word of the newest address entry joins that entry instead of opening a new one. As long as that entry has not started draining, consecutive stores therefore share one address entry.

Dirty lines that the cache cleans or evicts never pass through the main queue. They are streamed one word per beat into a separate line store, which holds one address and up to eight words. A drain arbiter empties both stores through a single request/acknowledge memory port, one burst per address entry or line. It changes source only at a burst boundary, and a complete line goes ahead of the next queued burst. A lookup port lets the cache read around the buffer: any pending word can be returned from the buffer instead of from memory.

Top module: `postwr_buffer`

## Requirements
- R1: After reset `mem_req` and `lk_hit` are 0, and `wr_ready` and `ev_ready` are 1.
- R2: `wr_ready` is 0 exactly when the main queue holds sixteen words or four address entries. Otherwise it is 1.
- R3: An accepted store joins the newest address entry when its word address equals that entry's base plus its word count and that entry is not the burst now draining. Otherwise the store opens a new entry with a word count of 1.
- R4: Main entries drain oldest first, each as one burst. Beat k of a burst carries address base+k and the k-th oldest queued word, and `mem_last` is 1 on the final beat only.
- R5: While `mem_req` is 1 and `mem_ack` is 0, `mem_req`, `mem_addr`, `mem_data`, `mem_evict` and `mem_last` hold their values into the next cycle.
- R6: The line store takes one word per accepted `ev_valid` beat. The first word sets the line base address. The line is complete after a beat with `ev_last`=1 or after the eighth word, and `ev_ready` is 0 from completion until the last eviction beat is acknowledged.
- R7: Line words are drained with `mem_evict`=1 at addresses base+k, and they occupy no main queue slot.
- R8: The arbiter starts a burst only when idle. A complete line wins over a waiting main entry, and no burst is interrupted by the other source.
- R9: `lk_hit` is 1 when `lk_addr` matches a word held in either store. The data comes from the youngest matching main word, or from the line store when no main word matches.
- R10: A store offered while `wr_ready` is 0 is dropped and never appears on the memory port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Store offered to the main queue |
| wr_ready | output | 1 | Main queue can accept a store |
| wr_addr | input | AW | Word address of the store |
| wr_data | input | DW | Store data |
| ev_valid | input | 1 | Eviction word offered |
| ev_ready | output | 1 | Line store accepts eviction words |
| ev_addr | input | AW | Line base word address, used on the first word |
| ev_data | input | DW | Eviction word |
| ev_last | input | 1 | Final word of the line |
| lk_addr | input | AW | Lookup word address |
| lk_hit | output | 1 | Lookup address is pending in a store |
| lk_data | output | DW | Pending data for the lookup |
| mem_req | output | 1 | Memory write beat requested |
| mem_ack | input | 1 | Memory accepts the current beat |
| mem_addr | output | AW | Beat word address |
| mem_data | output | DW | Beat data |
| mem_evict | output | 1 | Beat comes from the line store |
| mem_last | output | 1 | Final beat of the burst |

## Verification
The assertions assume that the memory side follows the handshake: the beat in flight is retired by `mem_ack` only while `mem_req` is high. They also assume that eviction lines have addresses distinct from one another within a line, so that a lookup finds at most one line word. The bench drives `mem_ack` freely, which the design ignores while no request is pending. Each line's words are placed at base+k by the design itself, which satisfies the second assumption. Stores are offered whether or not `wr_ready` is high, so that dropped stores are also exercised.

// File: rtl/wbuf_pkg.sv
`timescale 1ns/1ps
package wbuf_pkg;
    typedef enum logic [1:0] {ARB_IDLE, ARB_MAIN, ARB_EVICT} arb_state_e;
    typedef enum logic [1:0] {LINE_EMPTY, LINE_FILL, LINE_FULL} line_state_e;
endpackage

// File: rtl/wbuf_main_queue.sv
`timescale 1ns/1ps
// Main posted-write queue: word slots and address entries kept separately.
// DSLOTS and ASLOTS must be powers of two.
module wbuf_main_queue #(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int DSLOTS = 16,
    parameter int ASLOTS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    output logic          push_ready,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          burst_active,
    input  logic          pop,
    output logic          head_valid,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          head_last,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_hit,
    output logic [DW-1:0] lk_data
);
    localparam int DPW = $clog2(DSLOTS);
    localparam int APW = $clog2(ASLOTS);
    localparam int DCW = $clog2(DSLOTS + 1);
    localparam int ACW = $clog2(ASLOTS + 1);

    typedef struct packed {
        logic [DSLOTS-1:0][DW-1:0]  data;
        logic [DSLOTS-1:0][AW-1:0]  waddr;
        logic [ASLOTS-1:0][AW-1:0]  base;
        logic [ASLOTS-1:0][DCW-1:0] len;
        logic [DPW-1:0]             d_rd;
        logic [DPW-1:0]             d_wr;
        logic [DCW-1:0]             d_cnt;
        logic [APW-1:0]             a_rd;
        logic [APW-1:0]             a_wr;
        logic [ACW-1:0]             a_cnt;
        logic [DCW-1:0]             beat;
    } mq_state_t;

    mq_state_t q, d;

    logic [APW-1:0] newest;
    logic           join_newest;
    logic           push_fire;
    logic [DPW-1:0] slot;

    always_comb begin
        newest      = q.a_wr - 1'b1;
        push_ready  = (q.d_cnt != DCW'(DSLOTS)) && (q.a_cnt != ACW'(ASLOTS));
        join_newest = (q.a_cnt != '0) && !(burst_active && q.a_cnt == ACW'(1))
                      && (push_addr == q.base[newest] + AW'(q.len[newest]));
        push_fire   = push_valid && push_ready;
        head_valid  = (q.a_cnt != '0);
        head_addr   = q.base[q.a_rd] + AW'(q.beat);
        head_data   = q.data[q.d_rd];
        head_last   = ((q.beat + 1'b1) == q.len[q.a_rd]);

        d = q;
        if (push_fire) begin
            d.data[q.d_wr]  = push_data;
            d.waddr[q.d_wr] = push_addr;
            d.d_wr          = q.d_wr + 1'b1;
            if (join_newest) begin
                d.len[newest] = q.len[newest] + 1'b1;
            end else begin
                d.base[q.a_wr] = push_addr;
                d.len[q.a_wr]  = DCW'(1);
                d.a_wr         = q.a_wr + 1'b1;
            end
        end
        if (pop) begin
            d.d_rd = q.d_rd + 1'b1;
            if (head_last) begin
                d.a_rd = q.a_rd + 1'b1;
                d.beat = '0;
            end else begin
                d.beat = q.beat + 1'b1;
            end
        end
        d.d_cnt = q.d_cnt + DCW'(push_fire) - DCW'(pop);
        d.a_cnt = q.a_cnt + ACW'(push_fire && !join_newest) - ACW'(pop && head_last);
    end

    // Youngest matching word wins: later slots in age order overwrite.
    always_comb begin
        lk_hit  = 1'b0;
        lk_data = '0;
        slot    = '0;
        for (int i = 0; i < DSLOTS; i++) begin
            slot = q.d_rd + DPW'(i);
            if ((DCW'(i) < q.d_cnt) && (q.waddr[slot] == lk_addr)) begin
                lk_hit  = 1'b1;
                lk_data = q.data[slot];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/wbuf_evict_line.sv
`timescale 1ns/1ps
// Single-line eviction store: one base address, up to LWORDS words.
module wbuf_evict_line
    import wbuf_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int LWORDS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    input  logic          in_last,
    output logic          line_full,
    input  logic          pop,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_data,
    output logic          out_last,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_hit,
    output logic [DW-1:0] lk_data
);
    localparam int LPW = $clog2(LWORDS);
    localparam int LCW = $clog2(LWORDS + 1);

    typedef struct packed {
        logic [LWORDS-1:0][DW-1:0] words;
        logic [AW-1:0]             base;
        logic [LCW-1:0]            cnt;
        logic [LCW-1:0]            beat;
        line_state_e               state;
    } line_state_t;

    line_state_t q, d;

    always_comb begin
        in_ready  = (q.state != LINE_FULL);
        line_full = (q.state == LINE_FULL);
        out_addr  = q.base + AW'(q.beat);
        out_data  = q.words[q.beat[LPW-1:0]];
        out_last  = ((q.beat + 1'b1) == q.cnt);

        d = q;
        if (in_valid && in_ready) begin
            if (q.state == LINE_EMPTY) d.base = in_addr;
            d.words[q.cnt[LPW-1:0]] = in_data;
            d.cnt = q.cnt + 1'b1;
            if (in_last || q.cnt == LCW'(LWORDS - 1)) d.state = LINE_FULL;
            else                                      d.state = LINE_FILL;
        end
        if (pop) begin
            if (out_last) begin
                d.state = LINE_EMPTY;
                d.cnt   = '0;
                d.beat  = '0;
            end else begin
                d.beat  = q.beat + 1'b1;
            end
        end
    end

    always_comb begin
        lk_hit  = 1'b0;
        lk_data = '0;
        for (int i = 0; i < LWORDS; i++) begin
            if ((q.state != LINE_EMPTY) && (LCW'(i) < q.cnt)
                && (lk_addr == q.base + AW'(i))) begin
                lk_hit  = 1'b1;
                lk_data = q.words[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/wbuf_drain_arb.sv
`timescale 1ns/1ps
// Burst-granular arbiter between the main queue and the line store.
module wbuf_drain_arb
    import wbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic main_valid,
    input  logic main_last,
    input  logic line_full,
    input  logic line_last,
    input  logic mem_ack,
    output logic mem_req,
    output logic sel_main,
    output logic sel_line,
    output logic main_pop,
    output logic line_pop
);
    typedef struct packed {
        arb_state_e state;
    } arb_t;

    arb_t q, d;

    always_comb begin
        sel_main = (q.state == ARB_MAIN);
        sel_line = (q.state == ARB_EVICT);
        mem_req  = sel_main || sel_line;
        main_pop = sel_main && mem_ack;
        line_pop = sel_line && mem_ack;

        d = q;
        unique case (q.state)
            ARB_IDLE: begin
                if (line_full)       d.state = ARB_EVICT;
                else if (main_valid) d.state = ARB_MAIN;
            end
            ARB_MAIN:  if (mem_ack && main_last) d.state = ARB_IDLE;
            ARB_EVICT: if (mem_ack && line_last) d.state = ARB_IDLE;
            default:   d.state = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/postwr_buffer.sv
`timescale 1ns/1ps
module postwr_buffer #(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int DSLOTS = 16,
    parameter int ASLOTS = 4,
    parameter int LWORDS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          ev_valid,
    output logic          ev_ready,
    input  logic [AW-1:0] ev_addr,
    input  logic [DW-1:0] ev_data,
    input  logic          ev_last,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_hit,
    output logic [DW-1:0] lk_data,
    output logic          mem_req,
    input  logic          mem_ack,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data,
    output logic          mem_evict,
    output logic          mem_last
);
    logic          m_valid, m_last, m_pop, m_hit;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_data, m_lk_data;
    logic          l_full, l_last, l_pop, l_hit;
    logic [AW-1:0] l_addr;
    logic [DW-1:0] l_data, l_lk_data;
    logic          sel_main, sel_line;

    wbuf_main_queue #(.AW(AW), .DW(DW), .DSLOTS(DSLOTS), .ASLOTS(ASLOTS)) u_main (
        .clk(clk), .rst_n(rst_n),
        .push_valid(wr_valid), .push_ready(wr_ready),
        .push_addr(wr_addr), .push_data(wr_data),
        .burst_active(sel_main), .pop(m_pop),
        .head_valid(m_valid), .head_addr(m_addr), .head_data(m_data), .head_last(m_last),
        .lk_addr(lk_addr), .lk_hit(m_hit), .lk_data(m_lk_data)
    );

    wbuf_evict_line #(.AW(AW), .DW(DW), .LWORDS(LWORDS)) u_line (
        .clk(clk), .rst_n(rst_n),
        .in_valid(ev_valid), .in_ready(ev_ready),
        .in_addr(ev_addr), .in_data(ev_data), .in_last(ev_last),
        .line_full(l_full), .pop(l_pop),
        .out_addr(l_addr), .out_data(l_data), .out_last(l_last),
        .lk_addr(lk_addr), .lk_hit(l_hit), .lk_data(l_lk_data)
    );

    wbuf_drain_arb u_arb (
        .clk(clk), .rst_n(rst_n),
        .main_valid(m_valid), .main_last(m_last),
        .line_full(l_full), .line_last(l_last),
        .mem_ack(mem_ack), .mem_req(mem_req),
        .sel_main(sel_main), .sel_line(sel_line),
        .main_pop(m_pop), .line_pop(l_pop)
    );

    always_comb begin
        mem_evict = sel_line;
        mem_addr  = sel_line ? l_addr : m_addr;
        mem_data  = sel_line ? l_data : m_data;
        mem_last  = sel_line ? l_last : m_last;
        lk_hit    = m_hit || l_hit;
        lk_data   = m_hit ? m_lk_data : l_lk_data;
    end
endmodule

// File: rtl/postwr_buffer_chk.sv
`timescale 1ns/1ps
module postwr_buffer_chk #(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int DSLOTS = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic          ev_ready,
    input logic          mem_req,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_data,
    input logic          mem_evict,
    input logic          mem_last
);
    localparam int CW = $clog2(DSLOTS + 1) + 1;

    // Main words accepted minus main beats retired, seen only at the ports.
    logic [CW-1:0] main_words;
    always_ff @(posedge clk) begin
        if (!rst_n) main_words <= '0;
        else main_words <= main_words + CW'(wr_valid && wr_ready)
                           - CW'(mem_req && mem_ack && !mem_evict);
    end

    a_r2_stall_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (main_words == CW'(DSLOTS)) |-> !wr_ready);

    a_r7_main_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        main_words <= CW'(DSLOTS));

    a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data)
                                   && $stable(mem_evict) && $stable(mem_last)));

    a_r4_beat_address_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_last) |=> (mem_req && mem_addr == $past(mem_addr) + AW'(1)));

    a_r8_no_source_switch: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_last) |=> (mem_evict == $past(mem_evict)));

    a_r6_line_closed_while_draining: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_evict) |-> !ev_ready);
endmodule

bind postwr_buffer postwr_buffer_chk #(.AW(AW), .DW(DW), .DSLOTS(DSLOTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .ev_ready(ev_ready), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_evict(mem_evict), .mem_last(mem_last)
);

// File: tb/postwr_buffer_bench.sv
`timescale 1ns/1ps
module postwr_buffer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0, ev_valid = 1'b0, ev_last = 1'b0, mem_ack = 1'b0;
    logic [31:0] wr_addr = '0, wr_data = '0, ev_addr = '0, ev_data = '0, lk_addr = '0;
    logic        wr_ready, ev_ready, lk_hit, mem_req, mem_evict, mem_last;
    logic [31:0] lk_data, mem_addr, mem_data;

    int n_chk = 0;
    int n_fail = 0;
    int n_main_last = 0;

    always #5 clk = ~clk;

    postwr_buffer u_postwr_buffer (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_addr(ev_addr), .ev_data(ev_data),
        .ev_last(ev_last), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
        .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_evict(mem_evict), .mem_last(mem_last)
    );

    // Behavioural reference model
    logic [31:0] mq_addr[$];
    logic [31:0] mq_data[$];
    logic [31:0] ent_base[$];
    int          ent_cnt[$];
    int          beat, arb, ev_st, ev_cnt, ev_beat;
    logic [31:0] ev_base;
    logic [31:0] ev_w[8];

    task automatic model_reset();
        mq_addr.delete(); mq_data.delete(); ent_base.delete(); ent_cnt.delete();
        beat = 0; arb = 0; ev_st = 0; ev_cnt = 0; ev_beat = 0; ev_base = '0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        logic        e_wr_ready, e_ev_ready, e_req, e_last, e_evict, e_hit;
        logic [31:0] e_addr, e_data, e_lk;
        logic        wfire, efire, ack, joinq;
        int          arb_n;
        #1;
        e_wr_ready = (mq_data.size() < 16) && (ent_base.size() < 4);
        e_ev_ready = (ev_st != 2);
        e_req = (arb != 0);
        e_addr = '0; e_data = '0; e_last = 1'b0; e_evict = 1'b0;
        if (arb == 1) begin
            e_addr = ent_base[0] + beat; e_data = mq_data[0];
            e_last = (beat + 1 == ent_cnt[0]);
        end else if (arb == 2) begin
            e_addr = ev_base + ev_beat; e_data = ev_w[ev_beat];
            e_last = (ev_beat + 1 == ev_cnt); e_evict = 1'b1;
        end
        e_hit = 1'b0; e_lk = '0;
        foreach (mq_addr[i]) if (mq_addr[i] == lk_addr) begin e_hit = 1'b1; e_lk = mq_data[i]; end
        if (!e_hit && ev_st != 0)
            for (int i = 0; i < ev_cnt; i++)
                if (ev_base + i == lk_addr) begin e_hit = 1'b1; e_lk = ev_w[i]; end

        chk("R2 R10 wr_ready", {31'd0, wr_ready}, {31'd0, e_wr_ready});
        chk("R6 ev_ready", {31'd0, ev_ready}, {31'd0, e_ev_ready});
        chk("R8 mem_req", {31'd0, mem_req}, {31'd0, e_req});
        if (e_req) begin
            chk("R4 R5 mem_addr", mem_addr, e_addr);
            chk("R4 R10 mem_data", mem_data, e_data);
            chk("R7 R8 mem_evict", {31'd0, mem_evict}, {31'd0, e_evict});
            chk("R3 R4 mem_last", {31'd0, mem_last}, {31'd0, e_last});
        end
        chk("R9 lk_hit", {31'd0, lk_hit}, {31'd0, e_hit});
        if (e_hit) chk("R9 lk_data", lk_data, e_lk);
        if (mem_req && mem_ack && mem_last && !mem_evict) n_main_last++;

        wfire = wr_valid && e_wr_ready;
        efire = ev_valid && e_ev_ready;
        ack   = mem_ack && e_req;
        joinq = (ent_base.size() > 0) && !(arb == 1 && ent_base.size() == 1)
                && (wr_addr == ent_base[$] + ent_cnt[$]);
        arb_n = arb;
        if (arb == 0) begin
            if (ev_st == 2) arb_n = 2;
            else if (ent_base.size() > 0) arb_n = 1;
        end
        if (arb == 1 && ack) begin
            void'(mq_addr.pop_front()); void'(mq_data.pop_front());
            if (e_last) begin
                void'(ent_base.pop_front()); void'(ent_cnt.pop_front());
                beat = 0; arb_n = 0;
            end else beat++;
        end
        if (wfire) begin
            mq_addr.push_back(wr_addr); mq_data.push_back(wr_data);
            if (joinq) ent_cnt[ent_cnt.size() - 1]++;
            else begin ent_base.push_back(wr_addr); ent_cnt.push_back(1); end
        end
        if (arb == 2 && ack) begin
            if (e_last) begin ev_st = 0; ev_cnt = 0; ev_beat = 0; arb_n = 0; end
            else ev_beat++;
        end
        if (efire) begin
            if (ev_st == 0) ev_base = ev_addr;
            ev_w[ev_cnt] = ev_data;
            ev_cnt++;
            ev_st = (ev_last || ev_cnt == 8) ? 2 : 1;
        end
        arb = arb_n;
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        wr_valid = 1'b0; ev_valid = 1'b0; ev_last = 1'b0;
    endtask

    task automatic drain(input int n);
        idle_inputs(); mem_ack = 1'b1;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic put(input logic [31:0] a, input logic [31:0] dt);
        wr_valid = 1'b1; wr_addr = a; wr_data = dt; lk_addr = a;
        step();
        wr_valid = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state at the ports
        chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
        chk("R1 wr_ready", {31'd0, wr_ready}, 32'd1);
        chk("R1 ev_ready", {31'd0, ev_ready}, 32'd1);
        chk("R1 lk_hit", {31'd0, lk_hit}, 32'd0);
        @(negedge clk);

        // R3: coalescing while the head burst is held
        mem_ack = 1'b0;
        for (int i = 0; i < 4; i++) put(32'h100 + i, 32'hA000 + i);
        lk_addr = 32'h102; step();
        n_main_last = 0;
        drain(12);
        chk("R3 bursts for four stores", n_main_last, 2);

        // R2: word capacity with one long coalesced entry
        mem_ack = 1'b0;
        for (int i = 0; i < 18; i++) put(32'h200 + i, 32'hB000 + i);
        drain(24);

        // R2: address-entry capacity with scattered stores
        mem_ack = 1'b0;
        for (int i = 0; i < 6; i++) put(32'h300 + 16 * i, 32'hC000 + i);
        drain(16);

        // R6 R8: full line arrives while main entries wait
        mem_ack = 1'b0;
        for (int i = 0; i < 3; i++) put(32'h400 + 8 * i, 32'hD000 + i);
        for (int i = 0; i < 9; i++) begin
            ev_valid = 1'b1; ev_addr = 32'h500; ev_data = 32'hE000 + i; ev_last = 1'b0;
            lk_addr = 32'h500 + i;
            step();
        end
        idle_inputs();
        drain(24);

        // R6: short line closed by the last flag
        for (int i = 0; i < 3; i++) begin
            ev_valid = 1'b1; ev_addr = 32'h600; ev_data = 32'hF000 + i; ev_last = (i == 2);
            step();
        end
        drain(8);

        // Mixed random traffic
        begin
            logic [31:0] next_a;
            next_a = 32'h40;
            for (int c = 0; c < 4000; c++) begin
                wr_valid = ($urandom_range(0, 2) == 0);
                if ($urandom_range(0, 1) == 0) next_a = next_a + 1;
                else next_a = 32'h40 + $urandom_range(0, 63);
                wr_addr = next_a;
                wr_data = $urandom;
                ev_valid = ($urandom_range(0, 3) == 0);
                ev_addr = 32'h40 + $urandom_range(0, 63);
                ev_data = $urandom;
                ev_last = ($urandom_range(0, 2) == 0);
                mem_ack = ($urandom_range(0, 1) == 0);
                lk_addr = 32'h40 + $urandom_range(0, 70);
                step();
            end
        end
        drain(80);
        chk("R4 empty after drain", {31'd0, mem_req}, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule